// File: doc/BRIEF.md
# Tag-Driven I2C Master Byte Engine

This engine produces I2C master traffic from a stream of 10-bit command words taken from a transmit queue. Each word holds one byte plus two tag bits, one asking for a START before the byte and one asking for a STOP after it. The first byte after any START goes out as the slave address together with the direction bit. In write mode each later word sends its byte. In read mode each later word is only a placeholder that clocks one byte in from the slave. The received byte is pushed to a receive queue.

SCL timing comes from two programmable divisors, one for the high time and one for the low time, both counted in system clocks. The pads are open-drain. Each line is modelled as an output enable that pulls the line low, plus a sampled input. A slave that holds SCL low lengthens the high phase, because the high count only advances while SCL reads high. The engine reports a NACK from the slave, loss of arbitration, the end of a transfer, and a request for more data when the queue runs dry in the middle of a transfer.

Top module: `i2c_tag_master`

## Requirements
- R1: Command word fields: bits 7:0 hold the data byte, bit 8 requests a START and bit 9 requests a STOP. While idle, a word with bit 8 set causes a START followed by its byte sent as the address byte (7-bit address in bits 7:1, direction in bit 0, 1 = read). While idle, a word with bit 8 clear is consumed and discarded without any bus activity.
- R2: Bytes go out MSB first, and the engine releases SDA on the 9th clock. A slave ACK (SDA low) lets the transfer continue. A write word with bit 9 set ends with a STOP after its acknowledge bit.
- R3: A NACK from the slave on a byte the engine sent gives a one-cycle `nack_evt` pulse, and a STOP follows.
- R4: In read mode each placeholder word clocks in one byte, and its data bits are ignored. The engine ACKs that byte by driving SDA low, unless the placeholder has bit 9 set; then it NACKs by releasing SDA and issues a STOP. Each received byte appears on `rx_byte` with a one-cycle `rx_push` after its acknowledge bit.
- R5: A word with bit 8 set that arrives during a transfer causes a repeated START, and its byte is sent as the new address. A word with bits 8 and 9 both set causes a repeated START after its own byte instead of a STOP, and the next word is then sent as the address byte.
- R6: Within a byte, SCL stays released for `div_hi` clocks and pulled low for `div_lo` clocks.
- R7: A divisor value below 2 acts as 2.
- R8: When the queue is empty in the middle of a transfer that has no STOP pending, the engine holds SCL low and raises `tx_req` until a word arrives. The transfer then continues.
- R9: If the engine releases SDA to send a 1 but samples SDA low while SCL is high, it pulses `arb_evt`, releases both lines and returns to idle.
- R10: `bus_active` is high from the START until the STOP has completed. `done_evt` pulses once when the STOP completes.
- R11: During and right after reset both lines are released, and `bus_active`, `tx_req` and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Transmit queue holds a word |
| cmd_word | input | 10 | Head word: byte, START tag (bit 8), STOP tag (bit 9) |
| cmd_ready | output | 1 | Word is consumed when high together with cmd_valid |
| div_hi | input | DIV_W | SCL high time in system clocks |
| div_lo | input | DIV_W | SCL low time in system clocks |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sampled SDA level |
| tx_req | output | 1 | Waiting for a word in the middle of a transfer |
| rx_push | output | 1 | One-cycle push of a received byte |
| rx_byte | output | 8 | Received byte |
| bus_active | output | 1 | Transfer in progress on the bus |
| nack_evt | output | 1 | One-cycle pulse: slave did not acknowledge |
| arb_evt | output | 1 | One-cycle pulse: arbitration lost |
| done_evt | output | 1 | One-cycle pulse: STOP completed |

## Verification
Every phase boundary falls on a counter tick, and all event outputs are registered. `rx_push` and `nack_evt` therefore appear in the clock after the acknowledge high phase ends, which is the same clock in which SCL falls. `done_evt` and the fall of `bus_active` come together, `div_hi` clocks after SDA rises for the STOP. `arb_evt` appears one clock after the sampling point of the lost bit. The bench never predicts an absolute cycle for these. It drives words half a clock before an edge and samples at falling clock edges. It waits on the event pulses with a bounded loop, and it measures SCL high and low lengths by counting samples between line transitions, so each count equals the programmed divisor exactly.

// File: rtl/i2c_tag_master.sv
module i2c_tag_master #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [9:0]       cmd_word,
  output logic             cmd_ready,
  input  logic [DIV_W-1:0] div_hi,
  input  logic [DIV_W-1:0] div_lo,
  output logic             scl_oe,
  input  logic             scl_in,
  output logic             sda_oe,
  input  logic             sda_in,
  output logic             tx_req,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             bus_active,
  output logic             nack_evt,
  output logic             arb_evt,
  output logic             done_evt
);
  localparam logic [DIV_W-1:0] ONE = 1;
  localparam logic [DIV_W-1:0] TWO = 2;

  typedef enum logic [3:0] {IDLE, STA1, STA2, BLO, BHI, FETCH, RSL, STO1, STO2, STO3} st_t;
  st_t st;

  logic [9:0]       cur;
  logic [7:0]       sh;
  logic [3:0]       bitn;
  logic             rd, is_addr, have_addr, addr_next;
  logic [DIV_W-1:0] cnt;

  wire [DIV_W-1:0] hi_c = (div_hi < TWO) ? TWO : div_hi;
  wire [DIV_W-1:0] lo_c = (div_lo < TWO) ? TWO : div_lo;
  wire scl_rel  = (st == IDLE) || (st == STA1) || (st == STA2) || (st == BHI) || (st == STO2) || (st == STO3);
  wire [DIV_W-1:0] lim = scl_rel ? hi_c : lo_c;
  wire tick     = (cnt >= lim - ONE) && (!scl_rel || scl_in);
  wire txdir    = is_addr || !rd;
  wire ack_slot = (bitn == 4'd8);
  wire lost     = txdir && !ack_slot && sh[7] && !sda_in;

  assign scl_oe     = !scl_rel;
  assign cmd_ready  = (st == IDLE) || (st == FETCH);
  assign tx_req     = (st == FETCH) && !cmd_valid;
  assign bus_active = (st != IDLE);

  always_comb begin
    case (st)
      STA2, STO1, STO2: sda_oe = 1'b1;
      BLO, BHI:         sda_oe = ack_slot ? (!txdir && !cur[9]) : (txdir && !sh[7]);
      default:          sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cur <= '0; sh <= '0; bitn <= '0; cnt <= '0;
      rd <= 1'b0; is_addr <= 1'b0; have_addr <= 1'b0; addr_next <= 1'b0;
      rx_push <= 1'b0; rx_byte <= '0; nack_evt <= 1'b0; arb_evt <= 1'b0; done_evt <= 1'b0;
    end else begin
      rx_push <= 1'b0; nack_evt <= 1'b0; arb_evt <= 1'b0; done_evt <= 1'b0;
      if (st == IDLE || st == FETCH || tick) cnt <= '0;
      else if (!scl_rel || scl_in)           cnt <= cnt + ONE;
      case (st)
        IDLE: if (cmd_valid && cmd_word[8]) begin
          cur <= cmd_word; have_addr <= 1'b1; addr_next <= 1'b0; st <= STA1;
        end
        STA1: if (tick) st <= STA2;
        STA2: if (tick) begin
          if (have_addr) begin
            sh <= cur[7:0]; rd <= cur[0]; is_addr <= 1'b1; bitn <= '0; st <= BLO;
          end else begin
            addr_next <= 1'b1; st <= FETCH;
          end
        end
        BLO: if (tick) st <= BHI;
        BHI: if (tick) begin
          if (lost) begin
            arb_evt <= 1'b1; st <= IDLE;
          end else if (!ack_slot) begin
            sh <= {sh[6:0], sda_in}; bitn <= bitn + 4'd1; st <= BLO;
          end else begin
            is_addr <= 1'b0;
            if (!txdir) begin rx_push <= 1'b1; rx_byte <= sh; end
            if (txdir && sda_in) begin nack_evt <= 1'b1; st <= STO1; end
            else if (cur[9] && cur[8]) begin have_addr <= 1'b0; st <= RSL; end
            else if (cur[9]) st <= STO1;
            else st <= FETCH;
          end
        end
        FETCH: if (cmd_valid) begin
          cur <= cmd_word;
          if (cmd_word[8] && !addr_next) begin
            have_addr <= 1'b1; st <= RSL;
          end else begin
            sh <= cmd_word[7:0]; is_addr <= addr_next; bitn <= '0; st <= BLO;
            if (addr_next) rd <= cmd_word[0];
            addr_next <= 1'b0;
          end
        end
        RSL:  if (tick) st <= STA1;
        STO1: if (tick) st <= STO2;
        STO2: if (tick) st <= STO3;
        STO3: if (tick) begin done_evt <= 1'b1; st <= IDLE; end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tag_master_chk.sv
module i2c_tag_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic tx_req,
  input logic bus_active,
  input logic nack_evt,
  input logic arb_evt,
  input logic done_evt,
  input logic rx_push
);
  assert_hold_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (scl_oe && bus_active));

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_evt |-> (!scl_oe && !sda_oe && !bus_active));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (!bus_active && !scl_oe && !sda_oe));

  assert_active_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_active) |-> (done_evt || arb_evt));

  assert_nack_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |-> (scl_oe && bus_active));

  assert_rx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);
endmodule

bind i2c_tag_master i2c_tag_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_req(tx_req),
  .bus_active(bus_active), .nack_evt(nack_evt), .arb_evt(arb_evt),
  .done_evt(done_evt), .rx_push(rx_push)
);

// File: tb/i2c_tag_master_tb.sv
module i2c_tag_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cmd_valid, cmd_ready, scl_oe, sda_oe, tx_req, rx_push, bus_active;
  logic       nack_evt, arb_evt, done_evt, scl_in, sda_in;
  logic [9:0] cmd_word;
  logic [9:0] div_hi = 10'd5, div_lo = 10'd4;
  logic [7:0] rx_byte;
  logic       slv_low = 1'b0, arb_force = 1'b0, ack_en = 1'b1;

  assign scl_in = !scl_oe;
  assign sda_in = !(sda_oe || slv_low || arb_force);

  logic [9:0] fmem [0:63];
  int wp = 0, rp = 0;
  assign cmd_valid = (rp != wp);
  assign cmd_word  = fmem[rp % 64];
  always @(posedge clk) if (cmd_valid && cmd_ready) rp <= rp + 1;

  i2c_tag_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
    .div_hi(div_hi), .div_lo(div_lo), .scl_oe(scl_oe), .scl_in(scl_in), .sda_oe(sda_oe),
    .sda_in(sda_in), .tx_req(tx_req), .rx_push(rx_push), .rx_byte(rx_byte),
    .bus_active(bus_active), .nack_evt(nack_evt), .arb_evt(arb_evt), .done_evt(done_evt)
  );

  // bus monitor and slave model
  logic       pscl = 1'b1, psda = 1'b1, in_addr = 1'b0, mrd = 1'b0, rd_stop = 1'b0;
  logic [7:0] sr = '0;
  logic [7:0] rdata [0:7];
  logic [7:0] mb [0:63];
  logic       mack [0:63];
  logic [7:0] rxq [0:63];
  int bc = 0, rdi = 0, nb = 0, nstart = 0, nstop = 0, nrx = 0;
  int n_nack = 0, n_arb = 0, n_done = 0;
  int hi_len = 0, lo_len = 0, hi_seen = 0, lo_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nack_evt) n_nack++;
      if (arb_evt)  n_arb++;
      if (done_evt) n_done++;
      if (rx_push) begin rxq[nrx % 64] = rx_byte; nrx++; end
    end
    if (scl_in && pscl) begin
      if (psda && !sda_in) begin nstart++; bc = 0; in_addr = 1'b1; rd_stop = 1'b0; end
      else if (!psda && sda_in) nstop++;
    end
    if (!pscl && scl_in) begin
      if (bc >= 1 && bc <= 7) lo_seen = lo_len;
      if (bc < 8) sr = {sr[6:0], sda_in};
      else begin
        mb[nb % 64] = sr; mack[nb % 64] = sda_in; nb++;
        if (in_addr) mrd = sr[0];
        else if (mrd && sda_in) rd_stop = 1'b1;
      end
      bc++; hi_len = 0;
    end
    if (pscl && !scl_in) begin
      if (bc >= 1 && bc <= 8) hi_seen = hi_len;
      if (bc == 9) begin
        if (!in_addr && mrd) rdi++;
        bc = 0; in_addr = 1'b0;
      end
      slv_low = 1'b0;
      if (bc == 8 && (in_addr || !mrd)) slv_low = ack_en;
      else if (bc < 8 && mrd && !in_addr && !rd_stop) slv_low = !rdata[rdi % 8][7 - bc];
      lo_len = 0;
    end
    if (scl_in) hi_len++; else lo_len++;
    pscl = scl_in; psda = sda_in;
  end

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk);
    fmem[wp % 64] = w;
    wp++;
  endtask

  task automatic wait_done(input string req);
    int base = n_done;
    for (int i = 0; i < 20000 && n_done == base; i++) @(negedge clk);
    chk(req, 32'(n_done - base), 32'd1);
  endtask

  // vectors: [15:9] address, [8:1] data, [0] slave acks
  localparam logic [15:0] VEC [4] = '{
    {7'h50, 8'hA5, 1'b1},
    {7'h2B, 8'h3C, 1'b1},
    {7'h11, 8'hFF, 1'b0},
    {7'h7F, 8'h00, 1'b1}
  };

  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb0, ns0, np0, nn0, nr0, nd0, na0;
    for (int i = 0; i < 8; i++) rdata[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R11 scl_oe in reset", scl_oe, 0);
    chk("R11 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 bus_active after reset", bus_active, 0);
    chk("R11 tx_req after reset", tx_req, 0);
    chk("R11 events after reset", {nack_evt, arb_evt, done_evt, rx_push}, 0);

    // R1 idle discard
    ns0 = nstart;
    push({2'b00, 8'h12});
    repeat (5) @(negedge clk);
    chk("R1 discard consumed", cmd_valid, 0);
    chk("R1 discard no start", 32'(nstart - ns0), 0);
    chk("R1 discard bus idle", bus_active, 0);

    for (int v = 0; v < 4; v++) begin
      nb0 = nb; ns0 = nstart; np0 = nstop; nn0 = n_nack;
      ack_en = VEC[v][0];
      push({2'b01, VEC[v][15:9], 1'b0});
      push({2'b10, VEC[v][8:1]});
      repeat (30) @(negedge clk);
      chk("R10 bus_active during transfer", bus_active, 1);
      wait_done("R10 done pulse");
      chk("R1 address byte", mb[nb0 % 64], {VEC[v][15:9], 1'b0});
      chk("R2 stop issued", 32'(nstop - np0), 1);
      chk("R10 bus idle after stop", bus_active, 0);
      if (VEC[v][0]) begin
        chk("R2 data byte", mb[(nb0 + 1) % 64], VEC[v][8:1]);
        chk("R3 no nack", 32'(n_nack - nn0), 0);
      end else begin
        chk("R3 nack pulse", 32'(n_nack - nn0), 1);
        chk("R3 no data after nack", 32'(nb - nb0), 1);
      end
      repeat (5) @(negedge clk);
    end
    ack_en = 1'b1;
    chk("R6 high length", 32'(hi_seen), 5);
    chk("R6 low length", 32'(lo_seen), 4);

    // R7 clamp
    div_hi = 10'd0; div_lo = 10'd1;
    push({2'b01, 7'h33, 1'b0});
    push({2'b10, 8'h81});
    wait_done("R7 done");
    chk("R7 high clamp", 32'(hi_seen), 2);
    chk("R7 low clamp", 32'(lo_seen), 2);
    div_hi = 10'd5; div_lo = 10'd4;

    // R4 read with ack then nack
    nb0 = nb; np0 = nstop; nr0 = nrx;
    rdata[rdi % 8] = 8'hC3; rdata[(rdi + 1) % 8] = 8'h5A;
    push({2'b01, 7'h48, 1'b1});
    push({2'b00, 8'hEE});
    push({2'b10, 8'h77});
    wait_done("R4 read done");
    chk("R4 two bytes pushed", 32'(nrx - nr0), 2);
    chk("R4 first byte", rxq[nr0 % 64], 8'hC3);
    chk("R4 second byte", rxq[(nr0 + 1) % 64], 8'h5A);
    chk("R4 master ack first", mack[(nb0 + 1) % 64], 0);
    chk("R4 master nack last", mack[(nb0 + 2) % 64], 1);
    chk("R4 stop after nack", 32'(nstop - np0), 1);

    // R5 repeated start via tagged following word
    nb0 = nb; ns0 = nstart; np0 = nstop; nr0 = nrx;
    rdata[rdi % 8] = 8'h99;
    push({2'b01, 7'h20, 1'b0});
    push({2'b00, 8'h11});
    push({2'b01, 7'h21, 1'b1});
    push({2'b10, 8'h00});
    wait_done("R5 rs done");
    chk("R5 two starts", 32'(nstart - ns0), 2);
    chk("R5 one stop", 32'(nstop - np0), 1);
    chk("R5 second address", mb[(nb0 + 2) % 64], {7'h21, 1'b1});
    chk("R5 read after rs", rxq[nr0 % 64], 8'h99);

    // R5 start+stop on one word
    nb0 = nb; ns0 = nstart; np0 = nstop;
    push({2'b11, 7'h30, 1'b0});
    push({2'b00, 7'h31, 1'b0});
    push({2'b10, 8'h77});
    wait_done("R5 tagged rs done");
    chk("R5 tagged starts", 32'(nstart - ns0), 2);
    chk("R5 tagged stop count", 32'(nstop - np0), 1);
    chk("R5 next word is address", mb[(nb0 + 1) % 64], {7'h31, 1'b0});
    chk("R5 data after rs", mb[(nb0 + 2) % 64], 8'h77);

    // R8 queue underrun
    nb0 = nb;
    push({2'b01, 7'h40, 1'b0});
    repeat (200) @(negedge clk);
    chk("R8 tx_req raised", tx_req, 1);
    chk("R8 scl held low", scl_oe, 1);
    chk("R8 still active", bus_active, 1);
    push({2'b10, 8'h5E});
    wait_done("R8 resumed done");
    chk("R8 tx_req cleared", tx_req, 0);
    chk("R8 data after wait", mb[(nb0 + 1) % 64], 8'h5E);

    // R9 arbitration loss on a 1 bit
    na0 = n_arb; nd0 = n_done;
    push({2'b01, 7'h7F, 1'b0});
    push({2'b10, 8'h00});
    for (int i = 0; i < 2000 && !(bus_active && scl_oe); i++) @(negedge clk);
    for (int i = 0; i < 2000 && scl_oe; i++) @(negedge clk);
    arb_force = 1'b1;
    for (int i = 0; i < 200 && n_arb == na0; i++) @(negedge clk);
    chk("R9 arb pulse", 32'(n_arb - na0), 1);
    chk("R9 scl released", scl_oe, 0);
    chk("R9 sda released", sda_oe, 0);
    chk("R9 bus idle", bus_active, 0);
    arb_force = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 no done after arb", 32'(n_done - nd0), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule